// File: doc/BRIEF.md
# Cascadable Priority Encoder (16 requests, active-low)

This block takes a set of active-low request lines and reports, as an active-low binary code, the number of the highest-numbered request that is asserted. Requests below the winning one have no effect on the code. The block is built from identical eight-line banks that chain through an enable handshake. Each bank has an active-low enable input, an enable output that passes priority down to the next bank when the bank has nothing to report, and a group flag that says the bank holds a live request. The top module chains two banks by default into a 16-line, 4-bit encoder.

The upper bank takes the external enable. Its enable output feeds the lower bank. The low code bits of all banks are merged by an active-low OR, which is an AND of the active-low lines. The code bits above that are taken from the group flag of whichever bank won. Every output is purely combinational. No request is held or latched, so the outputs follow the inputs within the same cycle.

Top module: `prio_enc_cascade`

## Requirements
- R1: While `en_in_n` is 1, `code_n` is all ones and both `en_out_n` and `grp_n` are 1, whatever the request lines carry.
- R2: While `en_in_n` is 0 and every bit of `req_n` is 1, `code_n` is 4'b1111, `grp_n` is 1 and `en_out_n` is 0.
- R3: While `en_in_n` is 0 and at least one `req_n` bit is 0, `code_n` is the bitwise inverse of the index of the highest-numbered 0 bit of `req_n`. For example, a request on line 5 alone gives 4'b1010.
- R4: While `en_in_n` is 0 and at least one request is active, `grp_n` is 0 and `en_out_n` is 1. `grp_n` and `en_out_n` are therefore never both 0.
- R5: An active request on any of lines 15 to 8 forces `code_n[3]` to 0. Any active requests on lines 7 to 0 then have no effect on any output.
- R6: When only lines 7 to 0 carry active requests, `code_n[3]` is 1 and `code_n[2:0]` is the inverted index of the highest of them.
- R7: The outputs hold no state. After any change of the inputs, the outputs match R1 to R6 for the new inputs alone, independent of what was applied before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_in_n | input | 1 | Active-low enable for the whole chain |
| req_n | input | 16 | Active-low request lines; the higher index has priority |
| code_n | output | 4 | Active-low binary index of the winning request |
| en_out_n | output | 1 | Active-low: enabled and no request active (cascade to a lower chain) |
| grp_n | output | 1 | Active-low: enabled and at least one request active |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes the inputs just after a falling clock edge. It samples a quarter period later, well before the next rising edge, so each check sees the settled outputs for the applied inputs only. The no-storage check applies two different patterns back to back and compares each one against the model computed for that pattern alone.

// File: rtl/prio_enc_pkg.sv
package prio_enc_pkg;

   typedef enum logic [0:0] {
      SCAN_ASCEND  = 1'b0,
      SCAN_DESCEND = 1'b1
   } scan_style_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/prio_find.sv
module prio_find
   import prio_enc_pkg::*;
#(
   parameter int unsigned  WIDTH = 8,
   parameter scan_style_e  STYLE = SCAN_ASCEND,
   localparam int unsigned IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);

   if (!is_pow2(WIDTH) || WIDTH < 2) begin : g_bad_width
      $error("prio_find: WIDTH must be a power of two of at least 2");
   end

   assign any = |req;

   if (STYLE == SCAN_ASCEND) begin : g_ascend
      always_comb begin
         idx = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (req[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_descend
      always_comb begin
         logic hit;
         idx = '0;
         hit = 1'b0;
         for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i] && !hit) begin
               idx = IDX_W'(i);
               hit = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/prio_bank.sv
module prio_bank
   import prio_enc_pkg::*;
#(
   parameter int unsigned  REQ_W = 8,
   parameter scan_style_e  STYLE = SCAN_ASCEND,
   localparam int unsigned CODE_W = $clog2(REQ_W)
) (
   input  logic              en_n,
   input  logic [REQ_W-1:0]  req_n,
   output logic [CODE_W-1:0] code_n,
   output logic              eo_n,
   output logic              gs_n
);

   logic              live;
   logic [CODE_W-1:0] win;

   prio_find #(
      .WIDTH (REQ_W),
      .STYLE (STYLE)
   ) u_find (
      .req (~req_n),
      .any (live),
      .idx (win)
   );

   always_comb begin
      code_n = '1;
      eo_n   = 1'b1;
      gs_n   = 1'b1;
      if (!en_n) begin
         if (live) begin
            code_n = ~win;
            gs_n   = 1'b0;
         end else begin
            eo_n   = 1'b0;
         end
      end
   end

endmodule

// File: rtl/prio_enc_cascade.sv
module prio_enc_cascade
   import prio_enc_pkg::*;
#(
   parameter int unsigned  BANK_REQ   = 8,
   parameter int unsigned  BANK_COUNT = 2,
   parameter scan_style_e  STYLE      = SCAN_ASCEND,
   localparam int unsigned LOW_W      = $clog2(BANK_REQ),
   localparam int unsigned HIGH_W     = $clog2(BANK_COUNT),
   localparam int unsigned TOTAL_REQ  = BANK_REQ * BANK_COUNT,
   localparam int unsigned CODE_W     = LOW_W + HIGH_W
) (
   input  logic                 en_in_n,
   input  logic [TOTAL_REQ-1:0] req_n,
   output logic [CODE_W-1:0]    code_n,
   output logic                 en_out_n,
   output logic                 grp_n
);

   if (!is_pow2(BANK_COUNT) || BANK_COUNT < 2) begin : g_bad_count
      $error("prio_enc_cascade: BANK_COUNT must be a power of two of at least 2");
   end

   logic [BANK_COUNT:0]   chain_n;
   logic [LOW_W-1:0]      bank_code_n [BANK_COUNT];
   logic [BANK_COUNT-1:0] bank_gs_n;

   assign chain_n[BANK_COUNT] = en_in_n;

   for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
      prio_bank #(
         .REQ_W (BANK_REQ),
         .STYLE (STYLE)
      ) u_bank (
         .en_n   (chain_n[b+1]),
         .req_n  (req_n[b*BANK_REQ +: BANK_REQ]),
         .code_n (bank_code_n[b]),
         .eo_n   (chain_n[b]),
         .gs_n   (bank_gs_n[b])
      );
   end

   always_comb begin
      logic [LOW_W-1:0]  low_n;
      logic [HIGH_W-1:0] bank_idx;
      low_n    = '1;
      bank_idx = '0;
      for (int b = 0; b < BANK_COUNT; b++) begin
         low_n = low_n & bank_code_n[b];
         if (!bank_gs_n[b]) bank_idx = bank_idx | HIGH_W'(b);
      end
      code_n = {~bank_idx, low_n};
   end

   assign en_out_n = chain_n[0];
   assign grp_n    = &bank_gs_n;

endmodule

module prio_enc_chk #(
   parameter int unsigned TOTAL_REQ = 16,
   parameter int unsigned BANK_REQ  = 8,
   parameter int unsigned CODE_W    = 4
) (
   input logic                 en_in_n,
   input logic [TOTAL_REQ-1:0] req_n,
   input logic [CODE_W-1:0]    code_n,
   input logic                 en_out_n,
   input logic                 grp_n
);

   always_comb begin
      if (!$isunknown({en_in_n, req_n, code_n, en_out_n, grp_n})) begin
         if (en_in_n) begin
            a_r1_disabled_idle : assert (code_n == '1 && en_out_n && grp_n)
               else $error("R1 outputs not idle while disabled");
         end
         if (!en_in_n && req_n == '1) begin
            a_r2_enabled_empty : assert (code_n == '1 && grp_n && !en_out_n)
               else $error("R2 empty-request outputs wrong");
         end
         a_r4_grp_eo_exclusive : assert (en_in_n || (grp_n != en_out_n))
            else $error("R4 group and enable-out not complementary");
         if (!en_in_n && !req_n[TOTAL_REQ-1]) begin
            a_r3_top_line_wins : assert (code_n == '0)
               else $error("R3 top request did not win");
         end
         if (!en_in_n && !(&req_n[TOTAL_REQ-1 -: BANK_REQ])) begin
            a_r5_upper_bank_msb : assert (!code_n[CODE_W-1])
               else $error("R5 upper bank did not set code msb");
         end
         if (!en_in_n && (&req_n[TOTAL_REQ-1 -: BANK_REQ]) && !(&req_n[BANK_REQ-1:0])) begin
            a_r6_lower_bank_msb : assert (code_n[CODE_W-1])
               else $error("R6 lower bank set code msb");
         end
      end
   end

endmodule

bind prio_enc_cascade prio_enc_chk #(
   .TOTAL_REQ (TOTAL_REQ),
   .BANK_REQ  (BANK_REQ),
   .CODE_W    (CODE_W)
) u_chk (
   .en_in_n  (en_in_n),
   .req_n    (req_n),
   .code_n   (code_n),
   .en_out_n (en_out_n),
   .grp_n    (grp_n)
);

// File: tb/prio_enc_cascade_tb.sv
module prio_enc_cascade_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_in_n;
   logic [15:0] req_n;
   logic [3:0]  code_n;
   logic        en_out_n;
   logic        grp_n;

   int n_run  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prio_enc_cascade dut_i (
      .en_in_n  (en_in_n),
      .req_n    (req_n),
      .code_n   (code_n),
      .en_out_n (en_out_n),
      .grp_n    (grp_n)
   );

   // Expected {code_n, en_out_n, grp_n} from the requirements
   function automatic logic [5:0] model(input logic en_n, input logic [15:0] r);
      logic [3:0] c;
      logic eo, gs;
      c = 4'hF; eo = 1'b1; gs = 1'b1;
      if (!en_n) begin
         eo = 1'b0;
         for (int i = 0; i < 16; i++) begin
            if (!r[i]) begin
               c  = ~4'(i);
               gs = 1'b0;
               eo = 1'b1;
            end
         end
      end
      return {c, eo, gs};
   endfunction

   task automatic apply(input logic en_n, input logic [15:0] r);
      @(negedge clk);
      en_in_n = en_n;
      req_n   = r;
      #(CLK_PERIOD/4);
   endtask

   task automatic check(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {code_n, en_out_n, grp_n};
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s en_n=%b req_n=%h actual=%b expected=%b",
                  req, en_in_n, req_n, act, exp);
      end
   endtask

   task automatic t_reset_state();
      apply(1'b1, 16'hFFFF);
      check("R1 initial disabled", 6'b1111_1_1);
   endtask

   task automatic t_disabled();
      apply(1'b1, 16'h0000);
      check("R1 disabled all requests", 6'b1111_1_1);
      apply(1'b1, 16'h7FFE);
      check("R1 disabled mixed", 6'b1111_1_1);
   endtask

   task automatic t_idle();
      apply(1'b0, 16'hFFFF);
      check("R2 enabled no request", 6'b1111_0_1);
   endtask

   task automatic t_single_each();
      for (int i = 0; i < 16; i++) begin
         logic [15:0] r;
         r = 16'hFFFF;
         r[i] = 1'b0;
         apply(1'b0, r);
         check("R3 single request", {~4'(i), 1'b1, 1'b0});
         check("R4 group low with request", model(1'b0, r));
      end
   endtask

   task automatic t_multi();
      apply(1'b0, 16'hFFD6);   // lines 0,3,5 active -> 5
      check("R3 highest of three", 6'b1010_1_0);
      apply(1'b0, 16'h0000);   // all active -> 15
      check("R3 all active", 6'b0000_1_0);
      for (int k = 0; k < 40; k++) begin
         logic [15:0] r;
         r = 16'($urandom());
         apply(1'b0, r);
         check("R3 pattern", model(1'b0, r));
      end
   endtask

   task automatic t_upper_masks_lower();
      apply(1'b0, 16'hFEFF);   // line 8 only -> 8
      check("R5 line 8 alone", 6'b0111_1_0);
      apply(1'b0, 16'hFE00);   // line 8 plus all low lines -> still 8
      check("R5 low lines ignored", 6'b0111_1_0);
      apply(1'b0, 16'hBF5A);   // line 14 top -> 14
      check("R5 upper mix", 6'b0001_1_0);
   endtask

   task automatic t_lower_only();
      apply(1'b0, 16'hFF7F);   // line 7 -> 7
      check("R6 line 7", 6'b1000_1_0);
      apply(1'b0, 16'hFFFE);   // line 0 -> 0
      check("R6 line 0", 6'b1111_1_0);
      apply(1'b0, 16'hFFE9);   // lines 1,2,4 -> 4
      check("R6 lower mix", 6'b1011_1_0);
   endtask

   task automatic t_no_memory();
      apply(1'b0, 16'h7FFF);
      check("R7 first pattern", 6'b0000_1_0);
      apply(1'b0, 16'hFFFD);
      check("R7 follows new pattern", 6'b1110_1_0);
      apply(1'b0, 16'hFFFF);
      check("R7 release to idle", 6'b1111_0_1);
      apply(1'b1, 16'hFFFD);
      check("R7 disable after request", 6'b1111_1_1);
   endtask

   initial begin
      en_in_n = 1'b1;
      req_n   = 16'hFFFF;
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_disabled();
      t_idle();
      t_single_each();
      t_multi();
      t_upper_masks_lower();
      t_lower_only();
      t_no_memory();
      done = 1'b1;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
   end

   initial begin
      wait (done || cycles >= WATCHDOG);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule